// File: doc/BRIEF.md
# Keyed configuration port controller

This block gives a host a two-port window into a bank of configuration registers on a plain I/O bus made of an address, a write strobe, a read strobe and an 8-bit data bus. The window stays shut until the host writes a fixed key byte to the index port twice in a row. Once the window is open, the host writes a register number to the index port. It then reads or writes that register through the data port, which sits one address above the index port. A fixed exit byte written to the index port shuts the window again.

Registers below 30h are global. They hold the logical-device selector, the identity bytes, the per-function power controls, the port-location bit and a lock bit. Registers from 30h upward are stored once for each of four logical devices, and the selector register picks which copy is visible. The port-location bit takes its value after reset from a strap input that is sampled while reset is asserted, so the strap chooses where the port pair sits. Each device's active bit, base address and six extension bytes drive the function units as parallel outputs.

Top module: `cfg_port_ctrl`

## Requirements
- R1: The window opens only after two back-to-back writes of 83h to the index port. Any other access to the index or data port (a read, a write to the data port, or an index write of another value) clears the count, so the next 83h counts as the first.
- R2: Writing AAh to the index port while the window is open closes it, and the register index is kept. While the window is shut, data-port writes change nothing and data-port reads return FFh. Index-port reads always return FFh.
- R3: While the window is open, the data port (index port + 1) reads and writes the register selected by the most recent index write.
- R4: The strap is sampled during reset. Strap = 1 sets bit 6 of register 26h to 0, which puts the ports at 2Eh/2Fh. Strap = 0 sets that bit to 1, which puts them at 4Eh/4Fh. Writing that bit moves the ports at once.
- R5: Bits [1:0] of register 07h select the logical device. Registers 30h and above are held separately for each of devices 0 to 3 and reach only the selected copy. Registers below 30h do not depend on the selector.
- R6: Writing 1 to bit 0 of register 02h returns every configuration register to its reset value, including the port-location bit, which takes the latched strap again. Register 02h reads 00h. The window state and the index are unchanged.
- R7: Register 20h reads 71h and register 21h reads 1xh, where x is the revision parameter (10h by default). Writes to both registers are ignored.
- R8: Register 22h resets to 80h. Its bits 7, 6 and 5 drive func_pwr_o[2], [1] and [0], and 0 means the function is powered down.
- R9: While bit 5 of register 26h is set, writes to every register except 26h are ignored. Register 26h stays writable, so the lock can be cleared.
- R10: Unimplemented registers and reserved bits read as 0, and writes to them are dropped. Reserved bits are 07h bits [7:2], 22h bits [4:0], 26h bits 7 and [4:0], and 30h bits [7:1].
- R11: For each device, 30h bit 0 drives dev_active_o, and 60h and 61h drive the high and low bytes of dev_base_o. Registers F0h to F5h drive dev_ext_o slots 0 to 5. All of these reset to 00h, except device 2 slots 0 and 3 (FFh) and device 3 slots 0 and 1 (01h).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; the strap is sampled while it is low |
| strap_i | input | 1 | Port-location strap |
| bus_addr_i | input | ADDR_W | Host I/O address |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_rd_i | input | 1 | Read strobe, one cycle per access |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid in the cycle of the read |
| func_pwr_o | output | 3 | Power enables from register 22h bits 7:5 |
| dev_active_o | output | NDEV | Active bit for each logical device |
| dev_base_o | output | NDEV x 16 | Base address for each device, taken from 60h and 61h |
| dev_ext_o | output | NDEV x 6 x 8 | Extension bytes F0h to F5h for each device |

## Verification
The key is tried with a clean double write and with each kind of interruption: a data-port read between the two key bytes, and an index write of another value. This separates a true back-to-back detector from one that only counts key bytes. Banking is tested by writing a register through one device number and reading it back through other device numbers. Mixing global and banked indices shows whether the selector is wrongly applied below 30h. The lock, a move of the port pair, the soft reset and a second strap value each change where or whether an access lands. Each of these is followed by reads at both the old and the new location.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

    localparam int EXT_REGS = 6;

    localparam logic [7:0] KEY_ENTER = 8'h83;
    localparam logic [7:0] KEY_EXIT  = 8'hAA;

    localparam logic [7:0] IDX_SRST    = 8'h02;
    localparam logic [7:0] IDX_LDN     = 8'h07;
    localparam logic [7:0] IDX_ID_HI   = 8'h20;
    localparam logic [7:0] IDX_ID_LO   = 8'h21;
    localparam logic [7:0] IDX_PWR     = 8'h22;
    localparam logic [7:0] IDX_OPT     = 8'h26;
    localparam logic [7:0] IDX_BANK_LO = 8'h30;
    localparam logic [7:0] IDX_ACT     = 8'h30;
    localparam logic [7:0] IDX_BASE_HI = 8'h60;
    localparam logic [7:0] IDX_BASE_LO = 8'h61;
    localparam logic [7:0] IDX_EXT0    = 8'hF0;

    localparam logic [7:0] ID_HI_VAL = 8'h71;
    localparam logic [3:0] ID_LO_TOP = 4'h1;

    typedef enum logic [1:0] {
        KEY_IDLE = 2'd0,
        KEY_ONE  = 2'd1,
        KEY_OPEN = 2'd2
    } key_state_e;

    function automatic logic [7:0] ext_default(input int dev, input int slot);
        if (dev == 2 && (slot == 0 || slot == 3)) return 8'hFF;
        if (dev == 3 && (slot == 0 || slot == 1)) return 8'h01;
        return 8'h00;
    endfunction

endpackage

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
    import cfg_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_acc_i,
    input  logic       dat_acc_i,
    input  logic       idx_wr_i,
    input  logic [7:0] wdata_i,
    output logic       ext_mode_o,
    output logic [7:0] index_o
);

    typedef struct packed {
        key_state_e st;
        logic [7:0] index;
    } key_st_t;

    key_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (st_q.st)
            KEY_IDLE, KEY_ONE: begin
                if (idx_wr_i && wdata_i == KEY_ENTER) begin
                    st_d.st = (st_q.st == KEY_ONE) ? KEY_OPEN : KEY_ONE;
                end else if (idx_acc_i || dat_acc_i) begin
                    st_d.st = KEY_IDLE;
                end
            end
            KEY_OPEN: begin
                if (idx_wr_i) begin
                    if (wdata_i == KEY_EXIT) st_d.st = KEY_IDLE;
                    else                     st_d.index = wdata_i;
                end
            end
            default: st_d.st = KEY_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.st    <= KEY_IDLE;
            st_q.index <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ext_mode_o = (st_q.st == KEY_OPEN);
    assign index_o    = st_q.index;

    AST_KEY_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_mode_o) |-> $past(idx_wr_i && wdata_i == KEY_ENTER)); // R1
    AST_KEY_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st == KEY_ONE) && dat_acc_i |=> (st_q.st == KEY_IDLE)); // R1
    AST_KEY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        ext_mode_o && idx_wr_i && wdata_i == KEY_EXIT |=> !ext_mode_o); // R2
    AST_INDEX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !idx_wr_i |=> $stable(index_o)); // R3

endmodule

// File: rtl/cfg_global_regs.sv
module cfg_global_regs
    import cfg_port_pkg::*;
#(
    parameter int         LDN_W = 2,
    parameter logic [3:0] REV   = 4'h0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap_i,
    input  logic             wr_en_i,
    input  logic [7:0]       idx_i,
    input  logic [7:0]       wdata_i,
    output logic [7:0]       rdata_o,
    output logic             soft_rst_o,
    output logic [LDN_W-1:0] ldn_o,
    output logic             hefras_o,
    output logic             lock_o,
    output logic [2:0]       pwr_o
);

    localparam logic [2:0] PWR_RST = 3'b100;

    typedef struct packed {
        logic             strap;
        logic [LDN_W-1:0] ldn;
        logic [2:0]       pwr;
        logic             hefras;
        logic             lock;
    } g_st_t;

    g_st_t st_d, st_q;

    assign soft_rst_o = wr_en_i && (idx_i == IDX_SRST) && wdata_i[0];

    always_comb begin
        st_d = st_q;
        if (soft_rst_o) begin
            st_d.ldn    = '0;
            st_d.pwr    = PWR_RST;
            st_d.hefras = ~st_q.strap;
            st_d.lock   = 1'b0;
        end else if (wr_en_i) begin
            case (idx_i)
                IDX_LDN: st_d.ldn = wdata_i[LDN_W-1:0];
                IDX_PWR: st_d.pwr = wdata_i[7:5];
                IDX_OPT: begin
                    st_d.hefras = wdata_i[6];
                    st_d.lock   = wdata_i[5];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.strap  <= strap_i;
            st_q.ldn    <= '0;
            st_q.pwr    <= PWR_RST;
            st_q.hefras <= ~strap_i;
            st_q.lock   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (idx_i)
            IDX_LDN:   rdata_o = 8'(st_q.ldn);
            IDX_ID_HI: rdata_o = ID_HI_VAL;
            IDX_ID_LO: rdata_o = {ID_LO_TOP, REV};
            IDX_PWR:   rdata_o = {st_q.pwr, 5'b0};
            IDX_OPT:   rdata_o = {1'b0, st_q.hefras, st_q.lock, 5'b0};
            default:   rdata_o = 8'h00;
        endcase
    end

    assign ldn_o    = st_q.ldn;
    assign hefras_o = st_q.hefras;
    assign lock_o   = st_q.lock;
    assign pwr_o    = st_q.pwr;

    AST_SOFT_RST: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |=> (pwr_o == PWR_RST && ldn_o == '0 && !lock_o)); // R6
    AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(st_q.strap)); // R4

endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank
    import cfg_port_pkg::*;
#(
    parameter int DEV_ID = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     soft_rst_i,
    input  logic                     wr_en_i,
    input  logic [7:0]               idx_i,
    input  logic [7:0]               wdata_i,
    output logic [7:0]               rdata_o,
    output logic                     active_o,
    output logic [15:0]              base_o,
    output logic [EXT_REGS-1:0][7:0] ext_o
);

    localparam int SLOT_W = $clog2(EXT_REGS);

    typedef struct packed {
        logic                     act;
        logic [15:0]              base;
        logic [EXT_REGS-1:0][7:0] ext;
    } b_st_t;

    function automatic b_st_t bank_reset();
        b_st_t r;
        r.act  = 1'b0;
        r.base = '0;
        for (int k = 0; k < EXT_REGS; k++) r.ext[k] = ext_default(DEV_ID, k);
        return r;
    endfunction

    b_st_t st_d, st_q;

    logic [7:0]        off;
    logic              in_ext;
    logic [SLOT_W-1:0] slot;

    assign off    = idx_i - IDX_EXT0;
    assign in_ext = (idx_i >= IDX_EXT0) && (off < 8'(EXT_REGS));
    assign slot   = off[SLOT_W-1:0];

    always_comb begin
        st_d = st_q;
        if (soft_rst_i) begin
            st_d = bank_reset();
        end else if (wr_en_i) begin
            case (idx_i)
                IDX_ACT:     st_d.act        = wdata_i[0];
                IDX_BASE_HI: st_d.base[15:8] = wdata_i;
                IDX_BASE_LO: st_d.base[7:0]  = wdata_i;
                default: if (in_ext) st_d.ext[slot] = wdata_i;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= bank_reset();
        else        st_q <= st_d;
    end

    always_comb begin
        case (idx_i)
            IDX_ACT:     rdata_o = {7'b0, st_q.act};
            IDX_BASE_HI: rdata_o = st_q.base[15:8];
            IDX_BASE_LO: rdata_o = st_q.base[7:0];
            default:     rdata_o = in_ext ? st_q.ext[slot] : 8'h00;
        endcase
    end

    assign active_o = st_q.act;
    assign base_o   = st_q.base;
    assign ext_o    = st_q.ext;

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i && !soft_rst_i |=> $stable(st_q)); // R5

endmodule

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
    import cfg_port_pkg::*;
#(
    parameter int                ADDR_W = 16,
    parameter int                NDEV   = 4,
    parameter logic [ADDR_W-1:0] PORT_A = 'h2E,
    parameter logic [ADDR_W-1:0] PORT_B = 'h4E,
    parameter logic [3:0]        REV    = 4'h0
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               strap_i,
    input  logic [ADDR_W-1:0]                  bus_addr_i,
    input  logic                               bus_wr_i,
    input  logic                               bus_rd_i,
    input  logic [7:0]                         bus_wdata_i,
    output logic [7:0]                         bus_rdata_o,
    output logic [2:0]                         func_pwr_o,
    output logic [NDEV-1:0]                    dev_active_o,
    output logic [NDEV-1:0][15:0]              dev_base_o,
    output logic [NDEV-1:0][EXT_REGS-1:0][7:0] dev_ext_o
);

    localparam int LDN_W = (NDEV > 1) ? $clog2(NDEV) : 1;

    logic              ext_mode, hefras, lock, soft_rst;
    logic [7:0]        index, g_rdata;
    logic [LDN_W-1:0]  ldn;
    logic [ADDR_W-1:0] port_idx, port_dat;
    logic              hit_idx, hit_dat, idx_acc, dat_acc, idx_wr;
    logic              cfg_wr, wr_ok, g_wr, bank_sel;
    logic [NDEV-1:0][7:0] bank_rdata;

    assign port_idx = hefras ? PORT_B : PORT_A;
    assign port_dat = port_idx + ADDR_W'(1);
    assign hit_idx  = (bus_addr_i == port_idx);
    assign hit_dat  = (bus_addr_i == port_dat);
    assign idx_acc  = hit_idx && (bus_wr_i || bus_rd_i);
    assign dat_acc  = hit_dat && (bus_wr_i || bus_rd_i);
    assign idx_wr   = hit_idx && bus_wr_i;

    assign cfg_wr   = ext_mode && hit_dat && bus_wr_i;
    assign wr_ok    = cfg_wr && (!lock || index == IDX_OPT);
    assign bank_sel = (index >= IDX_BANK_LO);
    assign g_wr     = wr_ok && !bank_sel;

    cfg_key_fsm key_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx_acc_i  (idx_acc),
        .dat_acc_i  (dat_acc),
        .idx_wr_i   (idx_wr),
        .wdata_i    (bus_wdata_i),
        .ext_mode_o (ext_mode),
        .index_o    (index)
    );

    cfg_global_regs #(.LDN_W(LDN_W), .REV(REV)) glob_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_i    (strap_i),
        .wr_en_i    (g_wr),
        .idx_i      (index),
        .wdata_i    (bus_wdata_i),
        .rdata_o    (g_rdata),
        .soft_rst_o (soft_rst),
        .ldn_o      (ldn),
        .hefras_o   (hefras),
        .lock_o     (lock),
        .pwr_o      (func_pwr_o)
    );

    for (genvar i = 0; i < NDEV; i++) begin : g_bank
        logic bank_wr;
        assign bank_wr = wr_ok && bank_sel && (ldn == LDN_W'(i));

        cfg_dev_bank #(.DEV_ID(i)) bank_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .soft_rst_i (soft_rst),
            .wr_en_i    (bank_wr),
            .idx_i      (index),
            .wdata_i    (bus_wdata_i),
            .rdata_o    (bank_rdata[i]),
            .active_o   (dev_active_o[i]),
            .base_o     (dev_base_o[i]),
            .ext_o      (dev_ext_o[i])
        );
    end

    always_comb begin
        if (ext_mode && hit_dat) bus_rdata_o = bank_sel ? bank_rdata[ldn] : g_rdata;
        else                     bus_rdata_o = 8'hFF;
    end

    AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_mode && bus_rd_i && hit_dat |-> bus_rdata_o == 8'hFF); // R2
    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        lock && cfg_wr && index == IDX_PWR |=> $stable(func_pwr_o)); // R9
    AST_IDLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_mode && hit_dat && bus_wr_i |=> $stable(func_pwr_o) && $stable(dev_active_o)); // R2

endmodule

// File: tb/cfg_port_ctrl_tb_top.sv
module cfg_port_ctrl_tb_top;
    import cfg_port_pkg::*;

    localparam int NDEV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap = 1'b1;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [2:0]  func_pwr;
    logic [NDEV-1:0] dev_active;
    logic [NDEV-1:0][15:0] dev_base;
    logic [NDEV-1:0][EXT_REGS-1:0][7:0] dev_ext;

    int errors = 0;
    int checks = 0;
    logic [15:0] pa = 16'h002E;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    cfg_port_ctrl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .strap_i      (strap),
        .bus_addr_i   (bus_addr),
        .bus_wr_i     (bus_wr),
        .bus_rd_i     (bus_rd),
        .bus_wdata_i  (bus_wdata),
        .bus_rdata_o  (bus_rdata),
        .func_pwr_o   (func_pwr),
        .dev_active_o (dev_active),
        .dev_base_o   (dev_base),
        .dev_ext_o    (dev_ext)
    );

    // monitor: compares each read, mid-cycle, against the scoreboard queue
    always @(negedge clk) begin
        if (bus_rd) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                errors++;
                $display("FAIL %s: read @%h got %h expected %h", t, bus_addr, bus_rdata, e);
            end
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string t);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", t, act, exp);
        end
    endtask

    task automatic bwr(input logic [15:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic brd(input logic [15:0] a, input logic [7:0] e, input string t);
        @(posedge clk); #1;
        exp_q.push_back(e); tag_q.push_back(t);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic cwr(input logic [7:0] idx, input logic [7:0] d);
        bwr(pa, idx); bwr(pa + 16'd1, d);
    endtask

    task automatic crd(input logic [7:0] idx, input logic [7:0] e, input string t);
        bwr(pa, idx); brd(pa + 16'd1, e, t);
    endtask

    task automatic do_reset(input logic s);
        rst_n = 1'b0; strap = s;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got hung expected done");
        finish_run();
    end

    initial begin
        do_reset(1'b1);
        pa = 16'h002E;
        @(negedge clk);
        chk(func_pwr, 3'b100, "R8 reset power");
        chk(dev_active, 4'b0000, "R11 reset active");
        chk(dev_ext[2][0], 8'hFF, "R11 dev2 slot0");
        chk(dev_ext[3][1], 8'h01, "R11 dev3 slot1");

        brd(16'h002F, 8'hFF, "R2 idle data read");
        brd(16'h002E, 8'hFF, "R2 index read");

        // key interrupted by a data read, then by another index value
        bwr(16'h002E, 8'h83);
        brd(16'h002F, 8'hFF, "R1 break by read");
        bwr(16'h002E, 8'h83);
        bwr(16'h002E, 8'h07);
        bwr(16'h002E, 8'h83);
        brd(16'h002F, 8'hFF, "R1 break by index");
        bwr(16'h002E, 8'h83);
        bwr(16'h002E, 8'h83);

        crd(8'h20, 8'h71, "R1 R7 id hi");
        cwr(8'h20, 8'h00);
        crd(8'h20, 8'h71, "R7 id write ignored");
        crd(8'h21, 8'h10, "R7 id lo");
        crd(8'h22, 8'h80, "R8 power default");
        cwr(8'h22, 8'hFF);
        crd(8'h22, 8'hE0, "R10 power reserved");
        chk(func_pwr, 3'b111, "R8 power out");
        crd(8'h26, 8'h00, "R4 strap1 option");
        crd(8'h02, 8'h00, "R6 srst reads 0");
        crd(8'h2F, 8'h00, "R10 unimplemented");

        cwr(8'h07, 8'h01);
        cwr(8'h30, 8'hFF);
        crd(8'h30, 8'h01, "R10 active reserved");
        cwr(8'h60, 8'h12);
        cwr(8'h61, 8'h34);
        cwr(8'hF2, 8'h5A);
        cwr(8'h07, 8'h02);
        crd(8'h30, 8'h00, "R5 dev2 active");
        crd(8'hF2, 8'h00, "R5 dev2 slot2");
        crd(8'hF0, 8'hFF, "R11 dev2 F0");
        crd(8'hF3, 8'hFF, "R11 dev2 F3");
        cwr(8'h07, 8'h01);
        crd(8'h60, 8'h12, "R3 dev1 base hi");
        crd(8'hF2, 8'h5A, "R3 dev1 slot2");
        @(negedge clk);
        chk(dev_active, 4'b0010, "R11 active out");
        chk(dev_base[1], 16'h1234, "R11 base out");
        chk(dev_ext[1][2], 8'h5A, "R11 ext out");
        cwr(8'h07, 8'hFF);
        crd(8'h07, 8'h03, "R10 ldn reserved");
        crd(8'hF1, 8'h01, "R11 dev3 F1");
        crd(8'h22, 8'hE0, "R5 global unbanked");

        // lock
        cwr(8'h26, 8'h20);
        crd(8'h26, 8'h20, "R9 lock set");
        cwr(8'h22, 8'h00);
        crd(8'h22, 8'hE0, "R9 locked power");
        cwr(8'h07, 8'h00);
        crd(8'h07, 8'h03, "R9 locked ldn");
        cwr(8'h30, 8'h01);
        crd(8'h30, 8'h00, "R9 locked bank");
        cwr(8'h26, 8'h00);
        cwr(8'h22, 8'hA0);
        crd(8'h22, 8'hA0, "R9 unlocked");
        @(negedge clk);
        chk(func_pwr, 3'b101, "R8 power out 2");

        // move ports
        cwr(8'h26, 8'h40);
        brd(16'h002F, 8'hFF, "R4 old port dead");
        pa = 16'h004E;
        crd(8'h26, 8'h40, "R4 new port");

        // soft reset
        cwr(8'h02, 8'h01);
        pa = 16'h002E;
        brd(16'h002F, 8'h00, "R6 index kept");
        crd(8'h22, 8'h80, "R6 power back");
        crd(8'h07, 8'h00, "R6 ldn back");
        @(negedge clk);
        chk(dev_active, 4'b0000, "R6 active back");
        chk(dev_base[1], 16'h0000, "R6 base back");
        chk(dev_ext[1][2], 8'h00, "R6 ext back");
        chk(dev_ext[2][0], 8'hFF, "R6 ext default");

        // exit and idle write
        bwr(16'h002E, 8'h22);
        bwr(16'h002E, 8'hAA);
        brd(16'h002F, 8'hFF, "R2 after exit");
        bwr(16'h002F, 8'h00);
        bwr(16'h002E, 8'h83);
        bwr(16'h002E, 8'h83);
        brd(16'h002F, 8'h80, "R2 idle write dropped");
        @(negedge clk);
        chk(func_pwr, 3'b100, "R2 power untouched");

        // second strap value
        do_reset(1'b0);
        pa = 16'h004E;
        brd(16'h004F, 8'hFF, "R2 closed after reset");
        bwr(16'h004E, 8'h83);
        bwr(16'h004E, 8'h83);
        bwr(16'h004E, 8'h26);
        brd(16'h004F, 8'h40, "R4 strap0 option");
        brd(16'h002F, 8'hFF, "R4 strap0 low port dead");

        repeat (4) @(posedge clk);
        finish_run();
    end

endmodule